// File: doc/BRIEF.md
# MAC Address Table with Aging

This block is a small fully associative table of MAC addresses for a switch datapath. It learns the source addresses of frames and answers destination lookups. Each entry stores a 48-bit address, an egress port number, a two-bit age code and three exemption flags: static, authenticated and IP multicast. Ingress logic sends learn requests, each holding a source address and the port it arrived on. Forwarding logic sends lookup requests, each holding a destination address, and receives a registered hit flag and a port one cycle later. A periodic aging tick moves every entry that carries no flags one step towards the free code. A per-port fast-age vector flushes, in one cycle, all learned entries on the ports it selects. A host write port installs, refreshes or deletes entries at a chosen index.

Learn and lookup requests use valid/ready handshakes. A request is taken only on a cycle where both valid and ready are high. Lookup ready is high on every cycle outside reset. Learn ready is low on any cycle in which the host write port is active, so host writes take priority over learning and the learner must hold its request. The result outputs carry no ready signal. The consumer must take each result on the cycle it appears.

Top module: `mac_age_table`

## Requirements
- R1: An entry with any of its static, authenticated or IP multicast flags set keeps its age code unchanged through aging ticks and fast-age commands.
- R2: On each aging tick, an entry with no flags set steps its age code 2'b10 → 2'b11 → 2'b01 → 2'b00.
- R3: Age code 2'b00 marks a free entry. It stays 2'b00 on later ticks and never produces a lookup hit.
- R4: A learn of an address not in the table writes it into the lowest-index free entry, with age 2'b10 and all flags clear. learn_ok pulses high for one cycle on the following cycle.
- R5: A learn that matches a live entry with no flags set sets that entry's age to 2'b10 and replaces its port. A learn that matches an exempt entry leaves it unchanged. Either case raises learn_ok.
- R6: A learn that matches no entry while no entry is free leaves the table unchanged. learn_full pulses high for one cycle on the following cycle.
- R7: When fast_age bit p is high, every entry with no flags set and port p goes to age 2'b00. Entries on other ports and exempt entries are not changed.
- R8: When fast-age, an aging tick and a learn arrive in one cycle, fast-age is applied first, then the tick, then the learn. A learned entry therefore ends at age 2'b10.
- R9: A lookup is matched against the table state before the clock edge. On the next cycle result_valid is high and result_hit reports whether a live entry holds the address. result_port gives the port of the lowest-index match, or 0 on a miss.
- R10: A host write with host_delete low installs the address, port and flags at host_idx with age 2'b10. A host write with host_delete high clears the flags and sets age 2'b00.
- R11: learn_ready is low while host_valid is high. A learn presented in such a cycle is not taken and raises neither learn_ok nor learn_full.
- R12: After reset, every entry is free, all result and learn status outputs are low, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| learn_valid | input | 1 | Learn request present |
| learn_ready | output | 1 | Learn request can be taken |
| learn_mac | input | MAC_W | Source address to learn |
| learn_port | input | PORT_W | Ingress port of the source |
| learn_ok | output | 1 | Pulse: previous learn was stored or refreshed |
| learn_full | output | 1 | Pulse: previous learn was dropped, no free entry |
| lookup_valid | input | 1 | Lookup request present |
| lookup_ready | output | 1 | Lookup request can be taken |
| lookup_mac | input | MAC_W | Destination address to search |
| result_valid | output | 1 | Lookup result present |
| result_hit | output | 1 | Address found in a live entry |
| result_port | output | PORT_W | Port of the matched entry |
| age_tick | input | 1 | One aging step for all dynamic entries |
| fast_age | input | PORTS | Per-port flush of learned entries |
| host_valid | input | 1 | Host write this cycle |
| host_idx | input | IDX_W | Entry index for the host write |
| host_mac | input | MAC_W | Address to install |
| host_port | input | PORT_W | Port to install |
| host_static | input | 1 | Static flag to install |
| host_auth | input | 1 | Authenticated flag to install |
| host_ipmc | input | 1 | IP multicast flag to install |
| host_delete | input | 1 | Delete the entry instead of installing |

## Verification
The assertions assume that the host never installs an address that is already live in a second entry, so no lookup or learn can match more than one entry. They also assume that learn_port and host_port stay below PORTS. The random stimulus draws its port numbers in range. It spreads host installs over random indices, and the bench model resolves any duplicate the same way, by lowest index. The learn addresses come from a pool of 32 values, twice the default table size, so that learn hits, learn misses and a full table all occur.

// File: rtl/mat_pkg.sv
package mat_pkg;
  typedef enum logic [1:0] {
    AGE_FREE = 2'b00,
    AGE_OLD  = 2'b01,
    AGE_NEW  = 2'b10,
    AGE_MID  = 2'b11
  } age_t;

  typedef struct packed {
    logic st;
    logic au;
    logic im;
  } flags_t;

  function automatic age_t age_step(input age_t a);
    case (a)
      AGE_NEW: return AGE_MID;
      AGE_MID: return AGE_OLD;
      default: return AGE_FREE;
    endcase
  endfunction
endpackage

// File: rtl/mat_pick.sv
module mat_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mat_entry.sv
module mat_entry
  import mat_pkg::*;
#(
  parameter int PORTS = 8,
  parameter int MAC_W = 48,
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORTS-1:0]  fast_vec,
  input  logic              tick,
  input  logic              lrn_wr,
  input  logic [MAC_W-1:0]  lrn_mac,
  input  logic [PORT_W-1:0] lrn_port,
  input  logic              hw_sel,
  input  logic              hw_del,
  input  logic [MAC_W-1:0]  hw_mac,
  input  logic [PORT_W-1:0] hw_port,
  input  flags_t            hw_flags,
  output logic [MAC_W-1:0]  mac_q,
  output logic [PORT_W-1:0] port_q,
  output age_t              age_q,
  output age_t              age_mid,
  output logic              exempt
);
  flags_t flags_q;

  assign exempt = flags_q.st | flags_q.au | flags_q.im;

  // fast-age first, then the tick
  always_comb begin
    age_mid = age_q;
    if (!exempt && fast_vec[port_q]) age_mid = AGE_FREE;
    if (!exempt && tick)             age_mid = age_step(age_mid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_q   <= '0;
      port_q  <= '0;
      age_q   <= AGE_FREE;
      flags_q <= '0;
    end else if (hw_sel) begin
      if (hw_del) begin
        age_q   <= AGE_FREE;
        flags_q <= '0;
      end else begin
        mac_q   <= hw_mac;
        port_q  <= hw_port;
        flags_q <= hw_flags;
        age_q   <= AGE_NEW;
      end
    end else if (lrn_wr) begin
      mac_q   <= lrn_mac;
      port_q  <= lrn_port;
      flags_q <= '0;
      age_q   <= AGE_NEW;
    end else begin
      age_q <= age_mid;
    end
  end

  AST_EXEMPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (exempt && !hw_sel) |=> $stable(age_q)); // R1
  AST_AGE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!hw_sel && !lrn_wr && !exempt && tick && !fast_vec[port_q] && age_q == AGE_NEW)
      |=> age_q == AGE_MID); // R2
  AST_FREE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_FREE && !hw_sel && !lrn_wr) |=> age_q == AGE_FREE); // R3
  AST_FLUSH_PORT: assert property (@(posedge clk) disable iff (rst)
    (!hw_sel && !lrn_wr && !exempt && fast_vec[port_q]) |=> age_q == AGE_FREE); // R7
endmodule

// File: rtl/mac_age_table.sv
module mac_age_table
  import mat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 8,
  parameter int MAC_W   = 48,
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              learn_valid,
  output logic              learn_ready,
  input  logic [MAC_W-1:0]  learn_mac,
  input  logic [PORT_W-1:0] learn_port,
  output logic              learn_ok,
  output logic              learn_full,
  input  logic              lookup_valid,
  output logic              lookup_ready,
  input  logic [MAC_W-1:0]  lookup_mac,
  output logic              result_valid,
  output logic              result_hit,
  output logic [PORT_W-1:0] result_port,
  input  logic              age_tick,
  input  logic [PORTS-1:0]  fast_age,
  input  logic              host_valid,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [MAC_W-1:0]  host_mac,
  input  logic [PORT_W-1:0] host_port,
  input  logic              host_static,
  input  logic              host_auth,
  input  logic              host_ipmc,
  input  logic              host_delete
);
  logic [MAC_W-1:0]   e_mac  [ENTRIES];
  logic [PORT_W-1:0]  e_port [ENTRIES];
  age_t               e_age  [ENTRIES];
  age_t               e_mid  [ENTRIES];
  logic [ENTRIES-1:0] e_exempt, lrn_wr, hw_sel;
  logic [ENTRIES-1:0] lk_req, lk_gnt, lm_req, lm_gnt, fr_req, fr_gnt;
  logic               lk_any, lm_any, fr_any, lrn_go;
  logic [PORT_W-1:0]  lk_port;
  flags_t             hw_flags;

  assign learn_ready  = !rst && !host_valid;
  assign lookup_ready = !rst;
  assign lrn_go       = learn_valid && learn_ready;
  assign hw_flags     = '{st: host_static, au: host_auth, im: host_ipmc};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hw_sel[g] = host_valid && (host_idx == IDX_W'(g));
    assign lk_req[g] = (e_age[g] != AGE_FREE) && (e_mac[g] == lookup_mac);
    assign lm_req[g] = (e_mid[g] != AGE_FREE) && (e_mac[g] == learn_mac);
    assign fr_req[g] = (e_mid[g] == AGE_FREE);
    assign lrn_wr[g] = lrn_go && (lm_any ? (lm_gnt[g] && !e_exempt[g]) : fr_gnt[g]);

    mat_entry #(.PORTS(PORTS), .MAC_W(MAC_W)) u_ent (
      .clk(clk), .rst(rst), .fast_vec(fast_age), .tick(age_tick),
      .lrn_wr(lrn_wr[g]), .lrn_mac(learn_mac), .lrn_port(learn_port),
      .hw_sel(hw_sel[g]), .hw_del(host_delete), .hw_mac(host_mac),
      .hw_port(host_port), .hw_flags(hw_flags),
      .mac_q(e_mac[g]), .port_q(e_port[g]), .age_q(e_age[g]),
      .age_mid(e_mid[g]), .exempt(e_exempt[g])
    );
  end

  mat_pick #(.N(ENTRIES)) u_lk (.req(lk_req), .gnt(lk_gnt), .any(lk_any));
  mat_pick #(.N(ENTRIES)) u_lm (.req(lm_req), .gnt(lm_gnt), .any(lm_any));
  mat_pick #(.N(ENTRIES)) u_fr (.req(fr_req), .gnt(fr_gnt), .any(fr_any));

  always_comb begin
    lk_port = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_gnt[i]) lk_port = lk_port | e_port[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      result_hit   <= 1'b0;
      result_port  <= '0;
      learn_ok     <= 1'b0;
      learn_full   <= 1'b0;
    end else begin
      result_valid <= lookup_valid;
      result_hit   <= lookup_valid && lk_any;
      result_port  <= (lookup_valid && lk_any) ? lk_port : '0;
      learn_ok     <= lrn_go && (lm_any || fr_any);
      learn_full   <= lrn_go && !lm_any && !fr_any;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lrn_wr)); // R4
  AST_OK_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    !(learn_ok && learn_full)); // R6
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_ready) |=> result_valid); // R9
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    result_hit |-> result_valid); // R9
  AST_HOST_BLOCKS_LEARN: assert property (@(posedge clk) disable iff (rst)
    host_valid |=> (!learn_ok && !learn_full)); // R11
endmodule

// File: tb/sim_mac_age_table.sv
module sim_mac_age_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic learn_valid, learn_ready, learn_ok, learn_full;
  logic [47:0] learn_mac, lookup_mac, host_mac;
  logic [2:0] learn_port, result_port, host_port;
  logic lookup_valid, lookup_ready, result_valid, result_hit, age_tick;
  logic [7:0] fast_age;
  logic host_valid, host_static, host_auth, host_ipmc, host_delete;
  logic [3:0] host_idx;

  int n_run = 0, n_fail = 0;

  logic [47:0] m_mac [N];
  logic [2:0]  m_port[N];
  logic [1:0]  m_age [N];
  logic [2:0]  m_fl  [N];
  logic e_rv, e_hit, e_ok, e_full;
  logic [2:0] e_port;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_age_table u0 (
    .clk(clk), .rst(rst), .learn_valid(learn_valid), .learn_ready(learn_ready),
    .learn_mac(learn_mac), .learn_port(learn_port), .learn_ok(learn_ok),
    .learn_full(learn_full), .lookup_valid(lookup_valid), .lookup_ready(lookup_ready),
    .lookup_mac(lookup_mac), .result_valid(result_valid), .result_hit(result_hit),
    .result_port(result_port), .age_tick(age_tick), .fast_age(fast_age),
    .host_valid(host_valid), .host_idx(host_idx), .host_mac(host_mac),
    .host_port(host_port), .host_static(host_static), .host_auth(host_auth),
    .host_ipmc(host_ipmc), .host_delete(host_delete)
  );

  function automatic logic [47:0] mk(input int k);
    return {40'h02_00_5e_10_00, 3'b000, k[4:0]};
  endfunction

  function automatic logic [1:0] nxt(input logic [1:0] a);
    case (a)
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    learn_valid = 0; learn_mac = '0; learn_port = '0;
    lookup_valid = 0; lookup_mac = '0; age_tick = 0; fast_age = '0;
    host_valid = 0; host_idx = '0; host_mac = '0; host_port = '0;
    host_static = 0; host_auth = 0; host_ipmc = 0; host_delete = 0;
  endtask

  // reference model: expected outputs and next state from the requirements
  task automatic model();
    logic [1:0] mid [N];
    int hit_i, free_i;
    bit acc;
    e_rv = lookup_valid; e_hit = 0; e_port = '0;
    for (int i = 0; i < N; i++)
      if (lookup_valid && !e_hit && m_age[i] != 0 && m_mac[i] == lookup_mac) begin
        e_hit = 1; e_port = m_port[i];
      end
    for (int i = 0; i < N; i++) begin
      mid[i] = m_age[i];
      if (m_fl[i] == 0 && fast_age[m_port[i]]) mid[i] = 2'b00;
      if (m_fl[i] == 0 && age_tick) mid[i] = nxt(mid[i]);
    end
    acc = learn_valid && !host_valid;
    e_ok = 0; e_full = 0; hit_i = -1; free_i = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (mid[i] != 0 && m_mac[i] == learn_mac) hit_i = i;
      if (mid[i] == 0) free_i = i;
    end
    for (int i = 0; i < N; i++) m_age[i] = mid[i];
    if (acc) begin
      if (hit_i >= 0) begin
        e_ok = 1;
        if (m_fl[hit_i] == 0) begin m_age[hit_i] = 2'b10; m_port[hit_i] = learn_port; end
      end else if (free_i >= 0) begin
        e_ok = 1;
        m_mac[free_i] = learn_mac; m_port[free_i] = learn_port;
        m_fl[free_i] = 0; m_age[free_i] = 2'b10;
      end else e_full = 1;
    end
    if (host_valid) begin
      if (host_delete) begin m_age[host_idx] = 0; m_fl[host_idx] = 0; end
      else begin
        m_mac[host_idx] = host_mac; m_port[host_idx] = host_port;
        m_fl[host_idx] = {host_static, host_auth, host_ipmc}; m_age[host_idx] = 2'b10;
      end
    end
  endtask

  // inputs are set before the call, at a falling edge
  task automatic step(input string tag);
    #1;
    chk(learn_ready == !host_valid, {tag, " R11 learn_ready"}, learn_ready, !host_valid);
    model();
    @(posedge clk); #1;
    chk(result_valid == e_rv, {tag, " R9 result_valid"}, result_valid, e_rv);
    chk(result_hit == e_hit, {tag, " R9 result_hit"}, result_hit, e_hit);
    chk(result_port == e_port, {tag, " R9 result_port"}, result_port, e_port);
    chk(learn_ok == e_ok, {tag, " R4 learn_ok"}, learn_ok, e_ok);
    chk(learn_full == e_full, {tag, " R6 learn_full"}, learn_full, e_full);
    @(negedge clk);
    idle();
  endtask

  task automatic do_learn(input int k, input int p, input string tag);
    learn_valid = 1; learn_mac = mk(k); learn_port = 3'(p); step(tag);
  endtask

  task automatic do_look(input int k, input string tag);
    lookup_valid = 1; lookup_mac = mk(k); step(tag);
  endtask

  task automatic do_host(input int idx, input int k, input int p, input logic [2:0] fl,
                         input bit del, input string tag);
    host_valid = 1; host_idx = 4'(idx); host_mac = mk(k); host_port = 3'(p);
    {host_static, host_auth, host_ipmc} = fl; host_delete = del; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    idle();
    for (int i = 0; i < N; i++) begin m_mac[i] = '0; m_port[i] = '0; m_age[i] = 0; m_fl[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(result_valid == 0 && learn_ok == 0 && learn_full == 0, "R12 outputs after reset",
        {result_valid, learn_ok, learn_full}, 0);
    chk(learn_ready && lookup_ready, "R12 ready after reset", {learn_ready, lookup_ready}, 2'b11);
    @(negedge clk);
    do_look(1, "R12 empty lookup");
    chk(result_hit == 0, "R3 R12 empty table miss", result_hit, 0);

    do_learn(1, 3, "R4 learn");
    chk(learn_ok == 1, "R4 learn_ok pulse", learn_ok, 1);
    do_look(1, "R4 lookup");
    chk(result_hit && result_port == 3, "R4 hit port 3", {result_hit, result_port}, 4'hb);
    do_learn(1, 5, "R5 relearn");
    do_look(1, "R5 lookup");
    chk(result_port == 5, "R5 port replaced", result_port, 5);

    repeat (2) begin age_tick = 1; step("R2 tick"); end
    do_look(1, "R2 still live at 2'b01");
    chk(result_hit == 1, "R2 live before last step", result_hit, 1);
    age_tick = 1; step("R2 tick");
    do_look(1, "R3 aged out");
    chk(result_hit == 0, "R3 free entry no hit", result_hit, 0);

    do_host(7, 9, 6, 3'b100, 0, "R10 install static");
    repeat (5) begin age_tick = 1; step("R1 tick"); end
    do_look(9, "R1 static survives");
    chk(result_hit && result_port == 6, "R1 static kept", {result_hit, result_port}, 4'he);

    do_learn(2, 2, "R7 setup");
    do_learn(3, 4, "R7 setup");
    do_host(9, 4, 2, 3'b010, 0, "R7 setup auth");
    fast_age = 8'b0000_0100; step("R7 flush port 2");
    do_look(2, "R7 lookup flushed");
    chk(result_hit == 0, "R7 learned on port 2 cleared", result_hit, 0);
    do_look(3, "R7 other port");
    chk(result_hit == 1, "R7 other port kept", result_hit, 1);
    do_look(4, "R7 auth kept");
    chk(result_hit && result_port == 2, "R7 R1 auth entry untouched", {result_hit, result_port}, 4'ha);

    learn_valid = 1; learn_mac = mk(5); learn_port = 3'd1; age_tick = 1; fast_age = 8'b10;
    step("R8 combined");
    age_tick = 1; step("R8 tick after");
    do_look(5, "R8 lookup");
    chk(result_hit && result_port == 1, "R8 learn applied last", {result_hit, result_port}, 4'h9);

    host_valid = 1; host_idx = 4'd12; host_delete = 1; learn_valid = 1; learn_mac = mk(6);
    learn_port = 3'd0; step("R11 blocked learn");
    chk(learn_ok == 0 && learn_full == 0, "R11 no learn status", {learn_ok, learn_full}, 0);
    do_look(6, "R11 lookup");
    chk(result_hit == 0, "R11 learn not taken", result_hit, 0);

    do_host(7, 9, 6, 3'b000, 1, "R10 delete");
    do_look(9, "R10 deleted");
    chk(result_hit == 0, "R10 delete frees entry", result_hit, 0);

    for (int i = 0; i < N; i++) do_host(i, 0, 0, 3'b000, 1, "R6 clear");
    for (int i = 0; i < N; i++) do_learn(10 + i, i % 8, "R6 fill");
    do_learn(30, 1, "R6 overflow");
    chk(learn_full == 1 && learn_ok == 0, "R6 full pulse", {learn_ok, learn_full}, 1);
    do_look(30, "R6 dropped");
    chk(result_hit == 0, "R6 dropped learn absent", result_hit, 0);
    do_learn(12, 7, "R5 hit on full table");
    chk(learn_ok == 1, "R5 hit succeeds when full", learn_ok, 1);

    for (int c = 0; c < 4000; c++) begin
      learn_valid  = ($urandom % 2) == 0;
      learn_mac    = mk($urandom % 32);
      learn_port   = 3'($urandom % 8);
      lookup_valid = ($urandom % 3) != 0;
      lookup_mac   = mk($urandom % 32);
      age_tick     = ($urandom % 6) == 0;
      fast_age     = (($urandom % 20) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 25) == 0) begin
        host_valid  = 1;
        host_idx    = 4'($urandom % 16);
        host_mac    = mk(32 + $urandom % 8);
        host_port   = 3'($urandom % 8);
        {host_static, host_auth, host_ipmc} = 3'($urandom % 8);
        host_delete = ($urandom % 3) == 0;
      end
      step("R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule